// File: doc/BRIEF.md
# Complex half-band decimate-by-two filter

This block halves the sample rate of a complex (I/Q) stream with a real-valued, linear-phase half-band low-pass filter. It works only on the output samples it keeps. The impulse response is split into two polyphase branches. The even-indexed branch holds every non-zero tap except one. It is folded about its centre, so each distinct coefficient multiplies the sum of two samples. It is also time-multiplexed over a small number of multiplier banks. The odd-indexed branch holds only the centre tap, which is fixed at one half, so it reduces to an arithmetic shift with no multiplier.

Samples enter with a one-cycle valid strobe, at most one every K cycles. K is at least `HALF_LEN/BANKS`, the number of cycles each bank needs per output. One output is produced for every second accepted sample, so the output cadence is one every 2K cycles or slower. Each multiplier bank has one multiplier for I and one for Q. Several instances can be chained to reach larger decimation ratios. Each later stage sees half the sample rate, so it can run with fewer banks.

Top module: `halfband_decim2`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `outValid` is 0 and `outI`/`outQ` are 0. Reset clears the sample history to zero and restarts the phase count, so the first output follows the second sample accepted after reset.
- R2: Accepted samples are numbered 0, 1, 2, … from reset. A sample with an odd number triggers exactly one output. A sample with an even number triggers none.
- R3: `outValid` rises exactly `HALF_LEN/BANKS + 1` clock edges after the edge that accepts the triggering sample. That is 5 edges with the default parameters. It stays high for exactly one cycle.
- R4: Let N = 4·HALF_LEN−1 and c = 2·HALF_LEN−1. Output m equals Σₙ h[n]·x[2m+1−n] for n = 0…N−1, computed separately for I and Q at full precision with no rounding. Samples before reset count as 0. The taps are defined as follows: h[2i] = h[N−1−2i] = `COEFS[i]` for i < HALF_LEN; h[c] = 2^(COEF_FRAC−1); every other odd tap is 0.
- R5: A unit-height impulse of amplitude A at an even sample number p yields exactly one non-zero output, at m = p/2 + HALF_LEN − 1, of value A·2^(COEF_FRAC−1). All the others are zero.
- R6: An impulse of amplitude A at sample number 1 yields outputs m = 0 … 2·HALF_LEN−1 equal to A·h[2m]. These are `COEFS[0]` up to `COEFS[HALF_LEN−1]`, then the same values in mirrored order.
- R7: The `inI`/`inQ` values on cycles where `inValid` is 0 have no effect on any output.
- R8: While `outValid` is 0, `outI` and `outQ` keep the value of the most recent output.
- R9: The phase count advances per accepted sample, not per cycle, so gaps between samples longer than K cycles give the same output values.
- R10: Full-scale inputs of either sign never wrap: the outputs still match R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Accept strobe for `inI`/`inQ` |
| inI | input | DATA_W | In-phase input sample, two's complement |
| inQ | input | DATA_W | Quadrature input sample, two's complement |
| outValid | output | 1 | One-cycle strobe for a new decimated output |
| outI | output | DATA_W+COEF_W+clog2(HALF_LEN)+2 | In-phase output, full precision, COEF_FRAC fraction bits |
| outQ | output | DATA_W+COEF_W+clog2(HALF_LEN)+2 | Quadrature output, full precision, COEF_FRAC fraction bits |

## Verification
The bound checker follows the accept strobes on every cycle with its own phase count. It checks the timing side of the block: the quiet reset state, the fixed distance between an odd-numbered accept and the output strobe, that the strobe lasts a single cycle, and that the outputs hold between strobes. The arithmetic can only be shown by the bench's scenarios, which compare against a direct-form convolution. These cover the tap placement of the two branches through impulses at even and odd positions, mirrored tap order, immunity to data on idle cycles, irregular gaps, reset part-way through a stream, and full-scale inputs.

// File: rtl/hbdec_pkg.sv
package hbdec_pkg;
  // strobes sent from the sequencer to the arithmetic
  typedef struct packed {
    logic shift;   // accept a new sample into the history
    logic mac;     // a multiply step is active this cycle
    logic first;   // first step of an output: clear accumulators, latch centre
    logic last;    // final step of an output
  } hbCtrl_t;
endpackage

// File: rtl/halfband_decim2_ctrl.sv
module halfband_decim2_ctrl
  import hbdec_pkg::*;
#(
  parameter int STEPS  = 4,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output hbCtrl_t           ctrl,
  output logic [STEP_W-1:0] step
);
  logic phase;
  logic busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      busy  <= 1'b0;
      step  <= '0;
    end else begin
      if (inValid) phase <= ~phase;
      if (inValid && phase) begin
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        if (step == STEP_W'(STEPS - 1)) busy <= 1'b0;
        step <= step + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.shift = inValid;
    ctrl.mac   = busy;
    ctrl.first = busy && (step == '0);
    ctrl.last  = busy && (step == STEP_W'(STEPS - 1));
  end
endmodule

// File: rtl/halfband_decim2_datapath.sv
module halfband_decim2_datapath
  import hbdec_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 15,
  parameter int HALF_LEN  = 8,
  parameter int BANKS     = 2,
  parameter int STEP_W    = 2,
  parameter int ACC_W     = 37,
  parameter logic signed [COEF_W-1:0] COEFS [HALF_LEN] = '{default: '0}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  hbCtrl_t                  ctrl,
  input  logic [STEP_W-1:0]        step,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outI,
  output logic signed [ACC_W-1:0]  outQ
);
  localparam int NTAPS  = 4 * HALF_LEN - 1;
  localparam int CENTER = 2 * HALF_LEN - 1;
  localparam int STEPS  = HALF_LEN / BANKS;
  localparam int IDX_W  = $clog2(NTAPS);
  localparam int CI_W   = $clog2(HALF_LEN);
  localparam int PRE_W  = DATA_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;

  // sample history, index 0 is the newest
  logic signed [DATA_W-1:0] histI [NTAPS];
  logic signed [DATA_W-1:0] histQ [NTAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS; k++) begin
        histI[k] <= '0;
        histQ[k] <= '0;
      end
    end else if (ctrl.shift) begin
      histI[0] <= inI;
      histQ[0] <= inQ;
      for (int k = 1; k < NTAPS; k++) begin
        histI[k] <= histI[k-1];
        histQ[k] <= histQ[k-1];
      end
    end
  end

  // strobes delayed to line up with the registered products
  logic pValid, pFirst, pLast;
  always_ff @(posedge clk) begin
    if (rst) begin
      pValid <= 1'b0;
      pFirst <= 1'b0;
      pLast  <= 1'b0;
    end else begin
      pValid <= ctrl.mac;
      pFirst <= ctrl.first;
      pLast  <= ctrl.last;
    end
  end

  // centre branch: fixed tap of one half, a shift instead of a multiply
  logic signed [ACC_W-1:0] centerI, centerQ;
  always_ff @(posedge clk) begin
    if (rst) begin
      centerI <= '0;
      centerQ <= '0;
    end else if (ctrl.first) begin
      centerI <= ACC_W'(histI[CENTER]) <<< (COEF_FRAC - 1);
      centerQ <= ACC_W'(histQ[CENTER]) <<< (COEF_FRAC - 1);
    end
  end

  logic signed [ACC_W-1:0] accNextI [BANKS];
  logic signed [ACC_W-1:0] accNextQ [BANKS];

  // folded even branch, one multiplier pair per bank
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CI_W-1:0]          coefIdx;
    logic [IDX_W-1:0]         posNear, posFar;
    logic signed [PROD_W-1:0] preI, preQ, coefX;
    logic signed [PROD_W-1:0] prodI, prodQ;
    logic signed [ACC_W-1:0]  accI, accQ;

    always_comb begin
      coefIdx = CI_W'(b * STEPS) + CI_W'(step);
      posNear = IDX_W'(coefIdx) << 1;
      posFar  = IDX_W'(NTAPS - 1) - posNear;
      preI    = PROD_W'(PRE_W'(histI[posNear]) + PRE_W'(histI[posFar]));
      preQ    = PROD_W'(PRE_W'(histQ[posNear]) + PRE_W'(histQ[posFar]));
      coefX   = PROD_W'(COEFS[coefIdx]);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        prodI <= '0;
        prodQ <= '0;
      end else if (ctrl.mac) begin
        prodI <= preI * coefX;
        prodQ <= preQ * coefX;
      end
    end

    assign accNextI[b] = pFirst ? ACC_W'(prodI) : accI + ACC_W'(prodI);
    assign accNextQ[b] = pFirst ? ACC_W'(prodQ) : accQ + ACC_W'(prodQ);

    always_ff @(posedge clk) begin
      if (rst) begin
        accI <= '0;
        accQ <= '0;
      end else if (pValid) begin
        accI <= accNextI[b];
        accQ <= accNextQ[b];
      end
    end
  end

  logic signed [ACC_W-1:0] sumI, sumQ;
  always_comb begin
    sumI = centerI;
    sumQ = centerQ;
    for (int b = 0; b < BANKS; b++) begin
      sumI = sumI + accNextI[b];
      sumQ = sumQ + accNextQ[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outI     <= '0;
      outQ     <= '0;
    end else begin
      outValid <= pValid && pLast;
      if (pValid && pLast) begin
        outI <= sumI;
        outQ <= sumQ;
      end
    end
  end
endmodule

// File: rtl/halfband_decim2.sv
module halfband_decim2
  import hbdec_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 15,
  parameter int HALF_LEN  = 8,
  parameter int BANKS     = 2,
  parameter logic signed [COEF_W-1:0] COEFS [HALF_LEN] =
    '{-16'sd27, 16'sd61, -16'sd125, 16'sd233, -16'sd412, 16'sd729, -16'sd1408, 16'sd10369}
) (
  input  logic                                                   clk,
  input  logic                                                   rst,
  input  logic                                                   inValid,
  input  logic signed [DATA_W-1:0]                               inI,
  input  logic signed [DATA_W-1:0]                               inQ,
  output logic                                                   outValid,
  output logic signed [DATA_W+COEF_W+$clog2(HALF_LEN)+1:0]       outI,
  output logic signed [DATA_W+COEF_W+$clog2(HALF_LEN)+1:0]       outQ
);
  localparam int ACC_W   = DATA_W + COEF_W + $clog2(HALF_LEN) + 2;
  localparam int STEPS   = HALF_LEN / BANKS;
  localparam int STEP_W  = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int LATENCY = STEPS + 1;

  hbCtrl_t           ctrl;
  logic [STEP_W-1:0] step;

  halfband_decim2_ctrl #(.STEPS(STEPS), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .ctrl(ctrl), .step(step)
  );

  halfband_decim2_datapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
    .HALF_LEN(HALF_LEN), .BANKS(BANKS), .STEP_W(STEP_W),
    .ACC_W(ACC_W), .COEFS(COEFS)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .step(step),
    .inI(inI), .inQ(inQ),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );
endmodule

// File: rtl/halfband_decim2_checker.sv
module halfband_decim2_checker #(
  parameter int LATENCY = 5,
  parameter int OUT_W   = 37
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    inValid,
  input logic                    outValid,
  input logic signed [OUT_W-1:0] outI,
  input logic signed [OUT_W-1:0] outQ
);
  logic       phaseC;
  logic [7:0] sinceOdd;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseC   <= 1'b0;
      sinceOdd <= 8'hFF;
    end else begin
      if (inValid) phaseC <= ~phaseC;
      if (inValid && phaseC) sinceOdd <= 8'd0;
      else if (sinceOdd != 8'hFF) sinceOdd <= sinceOdd + 8'd1;
    end
  end

  // R1: reset leaves the outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!outValid && outI == '0 && outQ == '0));

  // R2, R3: a strobe only at the fixed distance from an odd-numbered accept
  a_r3_strobe_timing: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (sinceOdd == 8'(LATENCY)));

  // R2, R3: every odd-numbered accept produces its strobe
  a_r2_strobe_due: assert property (@(posedge clk) disable iff (rst)
    (sinceOdd == 8'(LATENCY)) |-> outValid);

  // R3: the strobe lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R8: outputs hold between strobes
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(outI) && $stable(outQ)));
endmodule

bind halfband_decim2 halfband_decim2_checker #(
  .LATENCY(HALF_LEN / BANKS + 1),
  .OUT_W(DATA_W + COEF_W + $clog2(HALF_LEN) + 2)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid),
  .outValid(outValid), .outI(outI), .outQ(outQ)
);

// File: tb/halfband_decim2_test.sv
module halfband_decim2_test;
  localparam int DATA_W    = 16;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 15;
  localparam int HALF_LEN  = 8;
  localparam int BANKS     = 2;
  localparam int K         = 4;
  localparam int STEPS     = HALF_LEN / BANKS;
  localparam int NTAPS     = 4 * HALF_LEN - 1;
  localparam int CENTER    = 2 * HALF_LEN - 1;
  localparam int OUT_W     = DATA_W + COEF_W + $clog2(HALF_LEN) + 2;
  localparam logic signed [COEF_W-1:0] COEFS [HALF_LEN] =
    '{-16'sd27, 16'sd61, -16'sd125, 16'sd233, -16'sd412, 16'sd729, -16'sd1408, 16'sd10369};

  localparam int NSTIM = 24;
  localparam int STIM_I [NSTIM] = '{ 1200, -3400, 5100, 32767, -32768, 77, 0, -1, 9000, -9000, 250, 31000,
                                     -15000, 4, 18000, -27000, 600, -600, 12345, -12345, 2, 30000, -20000, 8};
  localparam int STIM_Q [NSTIM] = '{ -500, 700, 32767, -32768, 100, -2200, 4400, 16000, -8, 3, -29000, 21000,
                                     0, 555, -7777, 7777, 32000, -31000, 1, -1, 1500, 2500, -3500, 4500};

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     inValid = 1'b0;
  logic signed [DATA_W-1:0] inI = '0;
  logic signed [DATA_W-1:0] inQ = '0;
  logic                     outValid;
  logic signed [OUT_W-1:0]  outI, outQ;

  always #2.5 clk = ~clk;

  halfband_decim2 #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
    .HALF_LEN(HALF_LEN), .BANKS(BANKS), .COEFS(COEFS)
  ) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inI(inI), .inQ(inQ),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  int     checks = 0;
  int     errors = 0;
  int     nIn    = 0;
  int     nGot   = 0;
  int     xI [64];
  int     xQ [64];
  longint gotI [64];
  longint gotQ [64];

  always @(negedge clk) begin
    if (!rst && outValid && nGot < 64) begin
      gotI[nGot] = outI;
      gotQ[nGot] = outQ;
      nGot++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint tapVal(input int n);
    if (n == CENTER) return longint'(1) <<< (COEF_FRAC - 1);
    if (n % 2 == 1) return 0;
    if (n / 2 < HALF_LEN) return longint'(COEFS[n / 2]);
    return longint'(COEFS[(NTAPS - 1 - n) / 2]);
  endfunction

  function automatic longint model(input int m, input bit useQ);
    longint s = 0;
    for (int n = 0; n < NTAPS; n++) begin
      int idx = 2 * m + 1 - n;
      if (idx >= 0 && idx < nIn) s += tapVal(n) * longint'(useQ ? xQ[idx] : xI[idx]);
    end
    return s;
  endfunction

  task automatic doReset();
    rst = 1'b1;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nIn = 0;
    nGot = 0;
  endtask

  task automatic sendSample(input int vi, input int vq, input int gap);
    inValid = 1'b1;
    inI = DATA_W'(vi);
    inQ = DATA_W'(vq);
    xI[nIn] = vi;
    xQ[nIn] = vq;
    nIn++;
    @(negedge clk);
    inValid = 1'b0;
    inI = 16'sh5A5A;   // junk on idle cycles (R7)
    inQ = -16'sh2C3D;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic compareAll(input string req);
    repeat (STEPS + 4) @(negedge clk);
    check(nGot == nIn / 2, {req, " output count"}, nGot, nIn / 2);
    for (int m = 0; m < nGot && m < nIn / 2; m++) begin
      check(gotI[m] == model(m, 1'b0), {req, " I value"}, gotI[m], model(m, 1'b0));
      check(gotQ[m] == model(m, 1'b1), {req, " Q value"}, gotQ[m], model(m, 1'b1));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic signed [OUT_W-1:0] held;
    // R1: reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 valid in reset", longint'(outValid), 0);
    check(outI == '0 && outQ == '0, "R1 data in reset", outI, 0);
    doReset();
    @(negedge clk);
    check(outValid == 1'b0, "R1 valid after reset", longint'(outValid), 0);

    // R4, R7: table walk at the nominal rate
    for (int s = 0; s < NSTIM; s++) sendSample(STIM_I[s], STIM_Q[s], K);
    compareAll("R4/R7 table");

    // R2, R3, R8: exact timing of one output
    doReset();
    sendSample(700, -300, K);
    check(nGot == 0, "R2 no output after even sample", nGot, 0);
    sendSample(-900, 1100, 1);
    repeat (STEPS) @(negedge clk);
    check(outValid == 1'b0, "R3 not early", longint'(outValid), 0);
    @(negedge clk);
    check(outValid == 1'b1, "R3 strobe at latency", longint'(outValid), 1);
    held = outI;
    check(outI == model(0, 1'b0), "R4 first output", outI, model(0, 1'b0));
    @(negedge clk);
    check(outValid == 1'b0, "R3 one cycle strobe", longint'(outValid), 0);
    check(outI == held, "R8 hold", outI, held);

    // R5: impulse at an even position reaches only the centre branch
    doReset();
    sendSample(1000, -2000, K);
    for (int s = 1; s < 4 * HALF_LEN; s++) sendSample(0, 0, K);
    compareAll("R5 centre impulse");
    check(gotI[HALF_LEN - 1] == (longint'(1000) <<< (COEF_FRAC - 1)), "R5 centre I",
          gotI[HALF_LEN - 1], longint'(1000) <<< (COEF_FRAC - 1));
    check(gotI[0] == 0, "R5 zero elsewhere", gotI[0], 0);

    // R6: impulse at position one reproduces the even taps in order and mirrored
    doReset();
    sendSample(0, 0, K);
    sendSample(3, -5, K);
    for (int s = 2; s < 4 * HALF_LEN + 2; s++) sendSample(0, 0, K);
    compareAll("R6 even taps");
    check(gotI[0] == 3 * longint'(COEFS[0]), "R6 first tap", gotI[0], 3 * longint'(COEFS[0]));
    check(gotQ[2 * HALF_LEN - 1] == -5 * longint'(COEFS[0]), "R6 mirrored last tap",
          gotQ[2 * HALF_LEN - 1], -5 * longint'(COEFS[0]));

    // R10: full scale of both signs
    doReset();
    for (int s = 0; s < 40; s++) sendSample(-32768, 32767, K);
    compareAll("R10 full scale");
    doReset();
    for (int s = 0; s < 40; s++) sendSample(s[0] ? 32767 : -32768, s[1] ? -32768 : 32767, K);
    compareAll("R10 alternating full scale");

    // R9: irregular gaps
    doReset();
    for (int s = 0; s < NSTIM; s++) sendSample(STIM_I[s], STIM_Q[s], K + (s * 5) % (2 * K + 1));
    compareAll("R9 irregular gaps");

    // R1: reset in mid-stream clears history and phase
    doReset();
    for (int s = 0; s < 5; s++) sendSample(20000, -20000, K);
    doReset();
    for (int s = 0; s < NSTIM; s++) sendSample(STIM_Q[s], STIM_I[s], K);
    compareAll("R1 restart after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule